// File: doc/BRIEF.md
# Dual-Core Writeback Commit Buffer

This block sits between the private write-through L1 caches of two cores that run the same thread redundantly and a shared L2. Each core pushes its L1-to-L2 writebacks (a cache-line address and its data) into a section of the buffer that belongs to that core alone. A line goes to L2 only once both cores have produced it. The two sections are matched oldest entry first. When the oldest entries of both sections carry the same address, both are retired and one copy of the line is written to L2.

The two cores never synchronize with each other. A faster core fills its own section while its entries wait for the slower core to produce the same addresses. A core whose section is full is told to stall. Writebacks it offers while stalled are dropped. If both sections hold entries and their oldest addresses disagree, the buffer raises a divergence flag and commits nothing until reset. Recovery is the job of logic outside this block.

Top module: `dual_wb_commit`

## Requirements
- R1: After synchronous reset both sections are empty and `a_stall`, `b_stall`, `l2_valid` and `diverge` are all 0.
- R2: Each core's writebacks are stored only in its own section, in the order they were accepted, and matched lines reach L2 in that same order.
- R3: When the oldest entries of both sections have equal addresses, `l2_valid` is 1 in the next cycle, with `l2_addr` set to that address and `l2_data` set to the data from the core A entry.
- R4: Each matched pair produces exactly one L2 write: `l2_valid` is high for a single cycle per pair, and both oldest entries are removed.
- R5: While either section is empty, no L2 write occurs. Entries from the run-ahead core wait in its section until the other core produces the matching addresses.
- R6: Each section holds DEPTH entries (default 10). A core's stall output is 1 exactly while its section holds DEPTH entries, and it returns to 0 once a commit frees a slot.
- R7: A writeback offered while the section is full is discarded and never takes part in a later match.
- R8: When both sections are non-empty and their oldest addresses differ, `diverge` is 1 from the next cycle. It stays 1 and no commit occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Core A offers a writeback this cycle |
| a_addr | input | ADDR_W | Core A cache-line address |
| a_data | input | DATA_W | Core A line data |
| a_stall | output | 1 | Core A section is full |
| b_wr | input | 1 | Core B offers a writeback this cycle |
| b_addr | input | ADDR_W | Core B cache-line address |
| b_data | input | DATA_W | Core B line data |
| b_stall | output | 1 | Core B section is full |
| l2_valid | output | 1 | One committed line is presented to L2 this cycle |
| l2_addr | output | ADDR_W | Committed line address |
| l2_data | output | DATA_W | Committed line data |
| diverge | output | 1 | Oldest addresses of the two sections disagree |

## Verification
The bound checker verifies the following on every cycle:
- Neither section's occupancy ever exceeds DEPTH.
- Each stall output equals that section's full condition.
- Every L2 write is caused by a head match in the previous cycle and carries the matched address.
- No L2 write follows a cycle in which either section was empty.
- The divergence flag only follows a cycle in which both sections were non-empty and held no match.

Only the bench scenarios can show properties that span many cycles of history:
- Lines run ahead by one core are committed later, in their original order.
- A writeback dropped while stalled never reappears in a later match.
- Data comes from core A.
- Divergence persists until reset.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic [1:0] {
    HEAD_IDLE  = 2'd0,
    HEAD_MATCH = 2'd1,
    HEAD_WAIT  = 2'd2,
    HEAD_SPLIT = 2'd3
  } head_state_e;
endpackage

// File: rtl/dwc_section.sv
module dwc_section #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 10,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     occ,
  output logic              full_q
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     occ_nxt;
  logic              accept, take;

  assign accept = wr_en && (occ != CW'(DEPTH));
  assign take   = pop && (occ != '0);

  always_comb begin
    occ_nxt = occ;
    if (accept && !take) occ_nxt = occ + CW'(1);
    else if (take && !accept) occ_nxt = occ - CW'(1);
  end

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_mem[wptr] <= wr_addr;
      data_mem[wptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      occ    <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
      if (take)   rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
      occ    <= occ_nxt;
      full_q <= (occ_nxt == CW'(DEPTH));
    end
  end

  assign head_addr = addr_mem[rptr];
  assign head_data = data_mem[rptr];
endmodule

// File: rtl/dwc_match.sv
module dwc_match #(
  parameter int ADDR_W = 32
) (
  input  logic                      a_busy,
  input  logic                      b_busy,
  input  logic [ADDR_W-1:0]         a_head,
  input  logic [ADDR_W-1:0]         b_head,
  output dwc_pkg::head_state_e      state
);
  import dwc_pkg::*;

  always_comb begin
    if (!a_busy && !b_busy)  state = HEAD_IDLE;
    else if (!a_busy || !b_busy) state = HEAD_WAIT;
    else if (a_head == b_head)   state = HEAD_MATCH;
    else                         state = HEAD_SPLIT;
  end
endmodule

// File: rtl/dual_wb_commit.sv
module dual_wb_commit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 10,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_data,
  output logic              a_stall,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_data,
  output logic              b_stall,
  output logic              l2_valid,
  output logic [ADDR_W-1:0] l2_addr,
  output logic [DATA_W-1:0] l2_data,
  output logic              diverge
);
  import dwc_pkg::*;

  logic              sec_wr   [2];
  logic [ADDR_W-1:0] sec_addr [2];
  logic [DATA_W-1:0] sec_data [2];
  logic [ADDR_W-1:0] hd_addr  [2];
  logic [DATA_W-1:0] hd_data  [2];
  logic [CW-1:0]     sec_occ  [2];
  logic              sec_full [2];
  logic              do_commit;
  logic [CW-1:0]     occ_a, occ_b;
  logic [ADDR_W-1:0] head_a_addr;
  head_state_e       hstate;

  assign sec_wr[0]   = a_wr;
  assign sec_addr[0] = a_addr;
  assign sec_data[0] = a_data;
  assign sec_wr[1]   = b_wr;
  assign sec_addr[1] = b_addr;
  assign sec_data[1] = b_data;

  for (genvar g = 0; g < 2; g++) begin : g_sec
    dwc_section #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_sec (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (sec_wr[g]),
      .wr_addr  (sec_addr[g]),
      .wr_data  (sec_data[g]),
      .pop      (do_commit),
      .head_addr(hd_addr[g]),
      .head_data(hd_data[g]),
      .occ      (sec_occ[g]),
      .full_q   (sec_full[g])
    );
  end

  dwc_match #(.ADDR_W(ADDR_W)) u_match (
    .a_busy(sec_occ[0] != '0),
    .b_busy(sec_occ[1] != '0),
    .a_head(hd_addr[0]),
    .b_head(hd_addr[1]),
    .state (hstate)
  );

  assign do_commit   = (hstate == HEAD_MATCH);
  assign occ_a       = sec_occ[0];
  assign occ_b       = sec_occ[1];
  assign head_a_addr = hd_addr[0];
  assign a_stall     = sec_full[0];
  assign b_stall     = sec_full[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      l2_valid <= 1'b0;
      diverge  <= 1'b0;
    end else begin
      l2_valid <= do_commit;
      diverge  <= (hstate == HEAD_SPLIT);
    end
  end

  always_ff @(posedge clk) begin
    if (do_commit) begin
      l2_addr <= hd_addr[0];
      l2_data <= hd_data[0];
    end
  end
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 10,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     occ_a,
  input logic [CW-1:0]     occ_b,
  input logic              a_stall,
  input logic              b_stall,
  input logic              do_commit,
  input logic [ADDR_W-1:0] head_a_addr,
  input logic              l2_valid,
  input logic [ADDR_W-1:0] l2_addr,
  input logic              diverge
);
  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (occ_a <= CW'(DEPTH)) && (occ_b <= CW'(DEPTH)));

  assert_stall_full_R6: assert property (@(posedge clk) disable iff (rst)
    (a_stall == (occ_a == CW'(DEPTH))) && (b_stall == (occ_b == CW'(DEPTH))));

  assert_commit_out_R3: assert property (@(posedge clk) disable iff (rst)
    do_commit |=> (l2_valid && (l2_addr == $past(head_a_addr))));

  assert_single_copy_R4: assert property (@(posedge clk) disable iff (rst)
    l2_valid |-> $past(do_commit));

  assert_wait_empty_R5: assert property (@(posedge clk) disable iff (rst)
    ((occ_a == '0) || (occ_b == '0)) |=> !l2_valid);

  assert_split_cause_R8: assert property (@(posedge clk) disable iff (rst)
    diverge |-> $past((occ_a != '0) && (occ_b != '0) && !do_commit));
endmodule

bind dual_wb_commit dwc_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .occ_a      (occ_a),
  .occ_b      (occ_b),
  .a_stall    (a_stall),
  .b_stall    (b_stall),
  .do_commit  (do_commit),
  .head_a_addr(head_a_addr),
  .l2_valid   (l2_valid),
  .l2_addr    (l2_addr),
  .diverge    (diverge)
);

// File: tb/sim_dual_wb_commit.sv
`timescale 1ns/1ps
module sim_dual_wb_commit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_wr = 1'b0, b_wr = 1'b0;
  logic [31:0] a_addr = '0, b_addr = '0;
  logic [63:0] a_data = '0, b_data = '0;
  logic        a_stall, b_stall, l2_valid, diverge;
  logic [31:0] l2_addr;
  logic [63:0] l2_data;

  int n_checks = 0;
  int n_fails  = 0;
  int log_n    = 0;
  logic [31:0] log_addr [32];
  logic [63:0] log_data [32];

  always #2.5 clk = ~clk;

  dual_wb_commit u0 (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_addr(a_addr), .a_data(a_data), .a_stall(a_stall),
    .b_wr(b_wr), .b_addr(b_addr), .b_data(b_data), .b_stall(b_stall),
    .l2_valid(l2_valid), .l2_addr(l2_addr), .l2_data(l2_data),
    .diverge(diverge)
  );

  always @(negedge clk) begin
    if (!rst && l2_valid && log_n < 32) begin
      log_addr[log_n] = l2_addr;
      log_data[log_n] = l2_data;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_wr = 1'b0; b_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    log_n = 0;
  endtask

  // drive one cycle of writebacks; returns at the negedge after the write edge
  task automatic put(input logic ea, input logic [31:0] aa, input logic [63:0] da,
                     input logic eb, input logic [31:0] ab, input logic [63:0] db);
    @(negedge clk);
    a_wr = ea; a_addr = aa; a_data = da;
    b_wr = eb; b_addr = ab; b_data = db;
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(a_stall == 1'b0, "R1 a_stall after reset", 64'(a_stall), 64'd0);
    chk(b_stall == 1'b0, "R1 b_stall after reset", 64'(b_stall), 64'd0);
    chk(l2_valid == 1'b0, "R1 l2_valid after reset", 64'(l2_valid), 64'd0);
    chk(diverge == 1'b0, "R1 diverge after reset", 64'(diverge), 64'd0);
  endtask

  task automatic t_match();
    do_reset();
    put(1'b1, 32'h10, 64'hAAAA_0001, 1'b1, 32'h10, 64'hBBBB_0001);
    chk(l2_valid == 1'b0, "R3 no write in entry cycle", 64'(l2_valid), 64'd0);
    @(negedge clk);
    chk(l2_valid == 1'b1, "R3 write one cycle after match", 64'(l2_valid), 64'd1);
    chk(l2_addr == 32'h10, "R3 l2_addr", 64'(l2_addr), 64'h10);
    chk(l2_data == 64'hAAAA_0001, "R3 l2_data from core A", l2_data, 64'hAAAA_0001);
    @(negedge clk);
    chk(l2_valid == 1'b0, "R4 single pulse", 64'(l2_valid), 64'd0);
    idle(4);
    chk(log_n == 1, "R4 one L2 write per pair", 64'(log_n), 64'd1);
  endtask

  task automatic t_runahead();
    do_reset();
    for (int i = 0; i < 3; i++) put(1'b1, 32'h100 + 32'(i), 64'hC0 + 64'(i), 1'b0, '0, '0);
    idle(4);
    chk(log_n == 0, "R5 run-ahead entries wait", 64'(log_n), 64'd0);
    chk(diverge == 1'b0, "R5 no divergence while B empty", 64'(diverge), 64'd0);
    for (int i = 0; i < 3; i++) put(1'b0, '0, '0, 1'b1, 32'h100 + 32'(i), 64'hD0 + 64'(i));
    idle(4);
    chk(log_n == 3, "R5 all lines commit once B catches up", 64'(log_n), 64'd3);
    for (int i = 0; i < 3; i++) begin
      chk(log_addr[i] == 32'h100 + 32'(i), "R2 commit order", 64'(log_addr[i]), 64'h100 + 64'(i));
      chk(log_data[i] == 64'hC0 + 64'(i), "R2 data from own section", log_data[i], 64'hC0 + 64'(i));
    end
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 9; i++) put(1'b1, 32'h200 + 32'(i), 64'(i), 1'b0, '0, '0);
    chk(a_stall == 1'b0, "R6 no stall at 9 entries", 64'(a_stall), 64'd0);
    put(1'b1, 32'h209, 64'd9, 1'b0, '0, '0);
    chk(a_stall == 1'b1, "R6 stall at 10 entries", 64'(a_stall), 64'd1);
    chk(b_stall == 1'b0, "R6 other core not stalled", 64'(b_stall), 64'd0);
    put(1'b1, 32'h999, 64'h99, 1'b0, '0, '0);
    chk(a_stall == 1'b1, "R7 stall holds after dropped write", 64'(a_stall), 64'd1);
    for (int i = 0; i < 10; i++) put(1'b0, '0, '0, 1'b1, 32'h200 + 32'(i), 64'(i));
    idle(4);
    chk(log_n == 10, "R6 ten lines commit", 64'(log_n), 64'd10);
    chk(a_stall == 1'b0, "R6 stall released", 64'(a_stall), 64'd0);
    put(1'b0, '0, '0, 1'b1, 32'h999, 64'h99);
    idle(4);
    chk(log_n == 10, "R7 dropped write never matches", 64'(log_n), 64'd10);
    chk(diverge == 1'b0, "R7 A section left empty", 64'(diverge), 64'd0);
  endtask

  task automatic t_diverge();
    do_reset();
    put(1'b1, 32'h20, 64'h1, 1'b1, 32'h30, 64'h2);
    @(negedge clk);
    chk(diverge == 1'b1, "R8 divergence flagged", 64'(diverge), 64'd1);
    put(1'b0, '0, '0, 1'b1, 32'h20, 64'h3);
    idle(4);
    chk(log_n == 0, "R8 no commit while diverged", 64'(log_n), 64'd0);
    chk(diverge == 1'b1, "R8 divergence persists", 64'(diverge), 64'd1);
    do_reset();
    chk(diverge == 1'b0, "R1 reset clears divergence", 64'(diverge), 64'd0);
  endtask

  initial begin
    t_reset();
    t_match();
    t_runahead();
    t_full();
    t_diverge();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule